// File: doc/BRIEF.md
# Light-Load Mode Controller

This block decides, for each converter channel, whether it runs fixed-frequency PWM or the pulse-frequency power-save mode (PFM), and in PFM it produces the switching-burst enable for the power-stage sequencer. It sees a shared mode pin level, a protocol-busy flag from the serial decoder, two output-voltage comparator flags per channel and two average-current flags per channel.

A high mode pin, or a frame in reception, forces every channel into PWM without delay. Power-save is allowed again only once the pin has been low, with no frame in progress, for a programmable number of clock cycles. While power-save is allowed, each channel drops into PFM on its own when its load current is light. It then switches in bursts: a burst starts when the output sags below the skip threshold, lasts a minimum number of cycles, and continues until the output has recovered. A deeper sag below the skip-low threshold, or a heavy-load current flag, sends the channel back to PWM.

Top module: `lightload_mode_ctrl`

## Requirements
- R1: After reset every channel is in PWM: `pfmMode` and `burstEn` are all 0.
- R2: `modePin` passes through a two-flop synchronizer; once it is high, every channel in PFM shows `pfmMode` = 0 from the third rising edge after the pin rose.
- R3: `frameBusy` (synchronous) high forces every channel to PWM at the next rising edge and restarts the low-level timeout.
- R4: Power-save becomes allowed only after `TIMEOUT_CYCLES` consecutive rising edges at which the synchronized pin and `frameBusy` are both low; any high level restarts the count, and no channel enters PFM before then.
- R5: With power-save allowed, a channel in PWM moves to PFM (`pfmMode` = 1) at the edge after its `curBelow` bit is seen high; each channel does so independently of the others.
- R6: A PFM channel whose synchronized `skipBelow` bit (two-flop synchronizer) is high and that has no exit condition raises `burstEn` at the next rising edge.
- R7: Once started, a burst holds `burstEn` high for at least `MIN_BURST_CYCLES` cycles, even if the skip flag clears at once.
- R8: After the minimum, the burst continues while the synchronized skip flag stays high and ends at the first edge that sees it low.
- R9: A PFM channel returns to PWM at the next edge when its synchronized `skipLowBelow` bit or its `curAbove` bit is high; this takes priority over burst start and continuation.
- R10: `burstEn` is never high for a channel in PWM, whatever its skip flag does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modePin | input | 1 | Shared mode pin level, asynchronous; high forces PWM |
| frameBusy | input | 1 | Serial frame reception in progress, synchronous |
| skipBelow | input | NUM_CH | Output below skip threshold, asynchronous, per channel |
| skipLowBelow | input | NUM_CH | Output below skip-low threshold, asynchronous, per channel |
| curBelow | input | NUM_CH | Average current below PFM-enter threshold, synchronous |
| curAbove | input | NUM_CH | Average current above PFM-leave threshold, synchronous |
| pfmMode | output | NUM_CH | 1 when the channel is in power-save mode |
| burstEn | output | NUM_CH | 1 while the channel must switch in a PFM burst |

## Verification
Synchronous inputs act on the outputs one rising edge later, and asynchronous inputs three edges later (two synchronizer flops plus the state register); the power-save enable adds its timeout on top, so a light-load flag during the low-pin window shows at the edge after the timeout expires. The bench's reference model applies exactly these delays edge by edge and compares both outputs of every channel at each falling edge, where all registers have settled. Directed checks sample at the falling edge of the cycle named by the requirement, for example the third edge after a pin rise, and burst lengths are counted over a window longer than the burst.

// File: rtl/lightload_pkg.sv
package lightload_pkg;

  typedef enum logic [1:0] {
    CH_PWM       = 2'd0,
    CH_PFM_IDLE  = 2'd1,
    CH_PFM_BURST = 2'd2
  } chState_e;

  // strobes from control to the shared timeout counter
  typedef struct packed {
    logic clear;
    logic step;
  } tmrStrobe_t;

endpackage

// File: rtl/lightload_sync.sv
module lightload_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/lightload_datapath.sv
module lightload_datapath
  import lightload_pkg::*;
#(
  parameter int NUM_CH           = 2,
  parameter int TIMEOUT_CYCLES   = 1040,
  parameter int MIN_BURST_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        tmr,
  input  logic [NUM_CH-1:0] burstLoad,
  output logic              psEn,
  output logic [NUM_CH-1:0] minDone
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam int BW = $clog2(MIN_BURST_CYCLES + 1);

  logic [TW-1:0] lowCnt;

  // low-level timeout shared by all channels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      psEn   <= 1'b0;
    end else if (tmr.clear) begin
      lowCnt <= '0;
      psEn   <= 1'b0;
    end else if (tmr.step && !psEn) begin
      if (lowCnt == TW'(TIMEOUT_CYCLES - 1)) psEn <= 1'b1;
      else lowCnt <= lowCnt + TW'(1);
    end
  end

  p_ps_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    tmr.clear |=> !psEn);
  p_ps_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (psEn && !tmr.clear) |=> psEn);

  // per-channel minimum burst counters
  for (genvar g = 0; g < NUM_CH; g++) begin : gBurst
    logic [BW-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             cnt <= '0;
      else if (burstLoad[g]) cnt <= BW'(MIN_BURST_CYCLES - 1);
      else if (cnt != '0)    cnt <= cnt - BW'(1);
    end
    assign minDone[g] = (cnt == '0);
  end
endmodule

// File: rtl/lightload_control.sv
module lightload_control
  import lightload_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              forcePwm,
  input  logic              psEn,
  input  logic [NUM_CH-1:0] skipSync,
  input  logic [NUM_CH-1:0] skipLowSync,
  input  logic [NUM_CH-1:0] curBelow,
  input  logic [NUM_CH-1:0] curAbove,
  input  logic [NUM_CH-1:0] minDone,
  output tmrStrobe_t        tmr,
  output logic [NUM_CH-1:0] burstLoad,
  output logic [NUM_CH-1:0] pfmMode,
  output logic [NUM_CH-1:0] burstEn
);
  always_comb begin
    tmr.clear = forcePwm;
    tmr.step  = !forcePwm;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    chState_e st, nxt;
    logic     load;
    logic     leave;

    assign leave = forcePwm || skipLowSync[g] || curAbove[g];

    always_comb begin
      nxt  = st;
      load = 1'b0;
      case (st)
        CH_PWM: begin
          if (psEn && !forcePwm && curBelow[g]) nxt = CH_PFM_IDLE;
        end
        CH_PFM_IDLE: begin
          if (leave) nxt = CH_PWM;
          else if (skipSync[g]) begin
            nxt  = CH_PFM_BURST;
            load = 1'b1;
          end
        end
        CH_PFM_BURST: begin
          if (leave) nxt = CH_PWM;
          else if (minDone[g] && !skipSync[g]) nxt = CH_PFM_IDLE;
        end
        default: nxt = CH_PWM;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) st <= CH_PWM;
      else       st <= nxt;
    end

    assign burstLoad[g] = load;
    assign pfmMode[g]   = (st != CH_PWM);
    assign burstEn[g]   = (st == CH_PFM_BURST);

    p_force_exit_r2: assert property (@(posedge clk) disable iff (!rstN)
      forcePwm |=> (st == CH_PWM));
    p_no_entry_r4: assert property (@(posedge clk) disable iff (!rstN)
      ((st == CH_PWM) && !psEn) |=> (st == CH_PWM));
    p_burst_start_r6: assert property (@(posedge clk) disable iff (!rstN)
      ((st == CH_PFM_IDLE) && skipSync[g] && !leave) |=> (st == CH_PFM_BURST));
    p_min_burst_r7: assert property (@(posedge clk) disable iff (!rstN)
      ((st == CH_PFM_BURST) && !minDone[g] && !leave) |=> (st == CH_PFM_BURST));
    p_exit_r9: assert property (@(posedge clk) disable iff (!rstN)
      ((st != CH_PWM) && (skipLowSync[g] || curAbove[g])) |=> (st == CH_PWM));
  end
endmodule

// File: rtl/lightload_mode_ctrl.sv
module lightload_mode_ctrl
  import lightload_pkg::*;
#(
  parameter int NUM_CH           = 2,
  parameter int TIMEOUT_CYCLES   = 1040,
  parameter int MIN_BURST_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modePin,
  input  logic              frameBusy,
  input  logic [NUM_CH-1:0] skipBelow,
  input  logic [NUM_CH-1:0] skipLowBelow,
  input  logic [NUM_CH-1:0] curBelow,
  input  logic [NUM_CH-1:0] curAbove,
  output logic [NUM_CH-1:0] pfmMode,
  output logic [NUM_CH-1:0] burstEn
);
  logic              modeSync;
  logic [NUM_CH-1:0] skipSync;
  logic [NUM_CH-1:0] skipLowSync;
  logic              forcePwm;
  logic              psEn;
  logic [NUM_CH-1:0] minDone;
  logic [NUM_CH-1:0] burstLoad;
  tmrStrobe_t        tmr;

  lightload_sync #(.W(1)) i_modeSync (
    .clk(clk), .rstN(rstN), .asyncIn(modePin), .syncOut(modeSync));
  lightload_sync #(.W(NUM_CH)) i_skipSync (
    .clk(clk), .rstN(rstN), .asyncIn(skipBelow), .syncOut(skipSync));
  lightload_sync #(.W(NUM_CH)) i_skipLowSync (
    .clk(clk), .rstN(rstN), .asyncIn(skipLowBelow), .syncOut(skipLowSync));

  assign forcePwm = modeSync | frameBusy;

  lightload_control #(.NUM_CH(NUM_CH)) i_control (
    .clk(clk), .rstN(rstN), .forcePwm(forcePwm), .psEn(psEn),
    .skipSync(skipSync), .skipLowSync(skipLowSync),
    .curBelow(curBelow), .curAbove(curAbove), .minDone(minDone),
    .tmr(tmr), .burstLoad(burstLoad), .pfmMode(pfmMode), .burstEn(burstEn));

  lightload_datapath #(
    .NUM_CH(NUM_CH), .TIMEOUT_CYCLES(TIMEOUT_CYCLES),
    .MIN_BURST_CYCLES(MIN_BURST_CYCLES)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .tmr(tmr), .burstLoad(burstLoad),
    .psEn(psEn), .minDone(minDone));

  p_burst_in_pfm_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((~pfmMode) & burstEn) == '0);
endmodule

// File: tb/test_lightload_mode_ctrl.sv
module test_lightload_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int TMO = 20;
  localparam int MINB = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modePin = 1'b1;
  logic frameBusy = 1'b0;
  logic [NCH-1:0] skipBelow = '0;
  logic [NCH-1:0] skipLowBelow = '0;
  logic [NCH-1:0] curBelow = '0;
  logic [NCH-1:0] curAbove = '0;
  logic [NCH-1:0] pfmMode;
  logic [NCH-1:0] burstEn;

  int nChecks = 0;
  int nFails = 0;
  string curReq = "R1";
  bit modelOn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lightload_mode_ctrl #(.NUM_CH(NCH), .TIMEOUT_CYCLES(TMO), .MIN_BURST_CYCLES(MINB))
  i_lightload_mode_ctrl (
    .clk(clk), .rstN(rstN), .modePin(modePin), .frameBusy(frameBusy),
    .skipBelow(skipBelow), .skipLowBelow(skipLowBelow),
    .curBelow(curBelow), .curAbove(curAbove),
    .pfmMode(pfmMode), .burstEn(burstEn));

  // behavioural reference: 0 = PWM, 1 = PFM waiting, 2 = PFM bursting
  int mMode[NCH];
  int mElapsed[NCH];
  int pinPipe[$];
  int skPipe[NCH][$];
  int slPipe[NCH][$];
  int lowRun;
  bit psOn;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun = 0; psOn = 0;
      pinPipe = '{0, 0};
      for (int c = 0; c < NCH; c++) begin
        mMode[c] = 0; mElapsed[c] = 0;
        skPipe[c] = '{0, 0}; slPipe[c] = '{0, 0};
      end
    end else begin
      bit fp;
      fp = (pinPipe[0] != 0) || frameBusy;
      for (int c = 0; c < NCH; c++) begin
        bit sk, sl;
        sk = skPipe[c][0] != 0;
        sl = slPipe[c][0] != 0;
        if (mMode[c] == 0) begin
          if (psOn && !fp && curBelow[c]) mMode[c] = 1;
        end else if (fp || sl || curAbove[c]) begin
          mMode[c] = 0;
        end else if (mMode[c] == 1) begin
          if (sk) begin mMode[c] = 2; mElapsed[c] = 0; end
        end else begin
          mElapsed[c]++;
          if (mElapsed[c] >= MINB && !sk) mMode[c] = 1;
        end
        void'(skPipe[c].pop_front()); skPipe[c].push_back(int'(skipBelow[c]));
        void'(slPipe[c].pop_front()); slPipe[c].push_back(int'(skipLowBelow[c]));
      end
      if (fp) begin lowRun = 0; psOn = 0; end
      else begin lowRun++; if (lowRun >= TMO) psOn = 1; end
      void'(pinPipe.pop_front()); pinPipe.push_back(int'(modePin));
    end
  end

  always @(negedge clk) begin
    if (modelOn) begin
      for (int c = 0; c < NCH; c++) begin
        nChecks++;
        if (pfmMode[c] != (mMode[c] != 0) || burstEn[c] != (mMode[c] == 2)) begin
          nFails++;
          $display("FAIL %s model ch%0d: pfm=%0b burst=%0b expected pfm=%0b burst=%0b",
                   curReq, c, pfmMode[c], burstEn[c], mMode[c] != 0, mMode[c] == 2);
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitN(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // hold skip flag of ch for 'hold' edges, count burst cycles over 'total'
  task automatic burstRun(int ch, int hold, int total, output int cnt);
    cnt = 0;
    @(negedge clk);
    skipBelow[ch] = 1'b1;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      if (i == hold - 1) skipBelow[ch] = 1'b0;
      if (burstEn[ch]) cnt++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int cnt;
    waitN(3);
    rstN = 1'b1;
    modelOn = 1;
    @(negedge clk);
    chk("R1 pfm", int'(pfmMode), 0);
    chk("R1 burst", int'(burstEn), 0);

    // R4: low timeout, restarted by a high pulse
    curReq = "R4";
    modePin = 1'b0; curBelow = 2'b01;
    waitN(10);
    chk("R4 early", int'(pfmMode[0]), 0);
    modePin = 1'b1; waitN(1); modePin = 1'b0;
    waitN(TMO);
    chk("R4 restarted", int'(pfmMode[0]), 0);
    curReq = "R5";
    waitN(5);
    chk("R5 ch0 enters", int'(pfmMode[0]), 1);
    chk("R5 ch1 stays", int'(pfmMode[1]), 0);

    // R6 R7: one-cycle skip pulse gives exactly the minimum burst
    curReq = "R7";
    burstRun(0, 1, 12, cnt);
    chk("R7 min burst", cnt, MINB);
    // R8: long skip extends the burst
    curReq = "R8";
    burstRun(0, 12, 20, cnt);
    chk("R8 extended burst", cnt, 12);
    chk("R6 back to wait", int'(burstEn[0]), 0);

    // R9: heavy current exits during a burst
    curReq = "R9";
    skipBelow[0] = 1'b1;
    waitN(5);
    chk("R6 bursting", int'(burstEn[0]), 1);
    curAbove[0] = 1'b1;
    waitN(1);
    chk("R9 current exit", int'(pfmMode[0]), 0);
    curAbove[0] = 1'b0; skipBelow[0] = 1'b0;
    waitN(3);
    curReq = "R5";
    curBelow[1] = 1'b1;
    waitN(3);
    chk("R5 ch1 enters", int'(pfmMode[1]), 1);
    curReq = "R9";
    skipLowBelow[1] = 1'b1;
    waitN(3);
    chk("R9 skip-low exit", int'(pfmMode[1]), 0);
    chk("R5 ch0 independent", int'(pfmMode[0]), 1);
    skipLowBelow[1] = 1'b0;
    waitN(4);

    // R3: frame in progress
    curReq = "R3";
    frameBusy = 1'b1;
    waitN(1);
    chk("R3 forced", int'(pfmMode), 0);
    waitN(4);
    frameBusy = 1'b0;
    waitN(10);
    chk("R3 timeout restarted", int'(pfmMode[0]), 0);
    waitN(15);
    chk("R3 power-save again", int'(pfmMode[0]), 1);

    // R2: pin high through the synchronizer
    curReq = "R2";
    modePin = 1'b1;
    waitN(2);
    chk("R2 not yet", int'(pfmMode[0]), 1);
    waitN(1);
    chk("R2 forced", int'(pfmMode), 0);

    // R10: skip flags ignored in PWM
    curReq = "R10";
    skipBelow = 2'b11;
    waitN(8);
    chk("R10 no burst in PWM", int'(burstEn), 0);
    skipBelow = 2'b00;
    waitN(3);

    modelOn = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule